// File: doc/BRIEF.md
# Two-Pulse Interrupt Acknowledge Sequencer

This block sits between up to eight interrupt request lines and a processor that acknowledges interrupts with two strobes on an active-low acknowledge line. It watches the request lines in edge or level mode, collects pending requests, and raises an interrupt output whenever an external priority resolver reports a winner. It does not rank requests itself. It presents its pending and in-service sets to the resolver and takes back a valid flag and a level number.

The first acknowledge strobe moves the winning level from pending to in-service and leaves the data bus idle. The second strobe places an 8-bit vector on the bus. The upper bits of that vector come from a base value and the low three bits hold the level number. In-service bits are cleared by an end-of-interrupt strobe, or at the end of the second strobe when automatic clearing is on.

In a cascade the block works either as master or as slave. As master it puts a slave's ID on three cascade lines between the two strobes. As slave it drives the vector only when the cascade inputs match its own ID. A software poll turns the next read strobe into an acknowledge that returns a status byte.

Top module: `intack_seq`

## Requirements
- R1: In edge mode (`lvl_mode_i`=0), a pending bit is set by a low-to-high step on its request line. It is dropped if the line goes low before acknowledge. A line that stays high after its acknowledge is not requested again.
- R2: In level mode (`lvl_mode_i`=1), a pending bit is set whenever its request line is high, including right after an acknowledge. It clears when the line goes low.
- R3: On the first acknowledge strobe, the resolver's winning level gains its in-service bit and loses its pending bit. At most one in-service bit is added per cycle, and the data bus stays undriven.
- R4: During the second strobe, `doe_o` is high and `dout_o` = {`vec_base_i`, level[2:0]}. The data bus is driven only while an acknowledge or read strobe was low in the previous cycle.
- R5: If no winner exists at the first strobe, the vector carries level 7 and no in-service bit changes.
- R6: With `aeoi_i`=1, the serviced in-service bit clears when the second strobe ends. With `aeoi_i`=0, it stays set until an EOI strobe names its level.
- R7: As cascade master (`casc_i`=1, `master_i`=1), for a level whose `slave_map_i` bit is 1, `cas_o` equals the level number from the end of the first strobe to the end of the second strobe. In that case the master does not drive the vector. At all other times `cas_o` is 0, and it is never nonzero outside master cascade mode.
- R8: As cascade slave (`casc_i`=1, `master_i`=0), the vector is driven on the second strobe only if `cas_i` equals `my_id_i`.
- R9: After a poll arm, the next read strobe returns bit 7 = request present, bits 6:3 = 0 and bits 2:0 = winning level, and it sets that in-service bit. A read strobe without a poll arm drives nothing and changes no state.
- R10: `int_o` is high only when the resolver reports a winner, no acknowledge sequence is in progress, and no poll read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_IRQ | Request lines |
| lvl_mode_i | input | 1 | 1 = level sensing, 0 = edge sensing |
| aeoi_i | input | 1 | Automatic in-service clear at the end of the second strobe |
| casc_i | input | 1 | Cascade operation enabled |
| master_i | input | 1 | In cascade: 1 = master, 0 = slave |
| slave_map_i | input | N_IRQ | Master: levels that have a slave attached |
| my_id_i | input | LW | Slave: own cascade ID |
| cas_i | input | LW | Slave: cascade lines from the master |
| vec_base_i | input | 8-LW | Upper vector bits |
| win_vld_i | input | 1 | Resolver: a winner exists |
| win_lvl_i | input | LW | Resolver: winning level |
| inta_n_i | input | 1 | Acknowledge strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| poll_arm_i | input | 1 | Poll command pulse |
| eoi_stb_i | input | 1 | End-of-interrupt strobe |
| eoi_lvl_i | input | LW | Level cleared by the EOI strobe |
| pend_o | output | N_IRQ | Pending set, to the resolver |
| insvc_o | output | N_IRQ | In-service set, to the resolver |
| int_o | output | 1 | Interrupt to the processor |
| cas_o | output | LW | Master: slave ID on the cascade lines |
| dout_o | output | 8 | Data bus out |
| doe_o | output | 1 | Data bus drive enable |

## Verification
The bench runs a behavioural reference alongside the design and compares every output on every clock.

- **Single edge request:** separates the first-strobe bookkeeping from the second-strobe vector.
- **Two simultaneous requests:** show that the resolver's choice is serviced and that nesting blocks the lower level until its EOI.
- **Request withdrawn before acknowledge:** exposes the default level-7 vector.
- **Level-held request:** shows re-request after acknowledge, which edge mode must not do.
- **Cascade runs, slave and non-slave levels as master and matching and mismatching IDs as slave:** tell apart who drives the bus.
- **Poll reads with and without arming:** show whether a read strobe acts as an acknowledge.

// File: rtl/intack_seq.sv
module intack_seq #(
  parameter int N_IRQ = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_IRQ-1:0]          irq_i,
  input  logic                      lvl_mode_i,
  input  logic                      aeoi_i,
  input  logic                      casc_i,
  input  logic                      master_i,
  input  logic [N_IRQ-1:0]          slave_map_i,
  input  logic [$clog2(N_IRQ)-1:0]  my_id_i,
  input  logic [$clog2(N_IRQ)-1:0]  cas_i,
  input  logic [7-$clog2(N_IRQ):0]  vec_base_i,
  input  logic                      win_vld_i,
  input  logic [$clog2(N_IRQ)-1:0]  win_lvl_i,
  input  logic                      inta_n_i,
  input  logic                      rd_n_i,
  input  logic                      poll_arm_i,
  input  logic                      eoi_stb_i,
  input  logic [$clog2(N_IRQ)-1:0]  eoi_lvl_i,
  output logic [N_IRQ-1:0]          pend_o,
  output logic [N_IRQ-1:0]          insvc_o,
  output logic                      int_o,
  output logic [$clog2(N_IRQ)-1:0]  cas_o,
  output logic [7:0]                dout_o,
  output logic                      doe_o
);
  localparam int LW = $clog2(N_IRQ);
  localparam logic [LW-1:0] LVL_DFLT = LW'(N_IRQ - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_ONE, PH_GAP, PH_TWO} phase_t;

  phase_t           phase_q, phase_d;
  logic [N_IRQ-1:0] irq_q, pend_q, isr_q, pend_d, isr_d;
  logic [N_IRQ-1:0] req_new, clr_req, aeoi_clr, eoi_clr;
  logic             inta_q, rd_q, hit_q, poll_q, prd_q;
  logic [LW-1:0]    lvl_q;
  logic [7:0]       pbyte_q;
  logic             a_fall, a_rise, r_fall, r_rise;
  logic             ack_cap, poll_cap, take;
  logic             slave_hit, vec_ok, vec_on, cas_win;

  function automatic logic [N_IRQ-1:0] bit_of(input logic [LW-1:0] l);
    return {{(N_IRQ-1){1'b0}}, 1'b1} << l;
  endfunction

  assign a_fall   = inta_q & ~inta_n_i;
  assign a_rise   = ~inta_q & inta_n_i;
  assign r_fall   = rd_q & ~rd_n_i;
  assign r_rise   = ~rd_q & rd_n_i;

  assign ack_cap  = (phase_q == PH_IDLE) & a_fall;
  assign poll_cap = (phase_q == PH_IDLE) & ~a_fall & poll_q & r_fall;
  assign take     = (ack_cap | poll_cap) & win_vld_i;

  assign clr_req  = take ? bit_of(win_lvl_i) : '0;
  assign aeoi_clr = (phase_q == PH_TWO && a_rise && aeoi_i && hit_q) ? bit_of(lvl_q) : '0;
  assign eoi_clr  = eoi_stb_i ? bit_of(eoi_lvl_i) : '0;

  assign req_new  = lvl_mode_i ? irq_i : (irq_i & ~irq_q);
  assign pend_d   = ((pend_q & irq_i) | req_new) & ~clr_req;
  assign isr_d    = (isr_q | clr_req) & ~aeoi_clr & ~eoi_clr;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (a_fall) phase_d = PH_ONE;
      PH_ONE:  if (a_rise) phase_d = PH_GAP;
      PH_GAP:  if (a_fall) phase_d = PH_TWO;
      PH_TWO:  if (a_rise) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      irq_q   <= '0;
      pend_q  <= '0;
      isr_q   <= '0;
      inta_q  <= 1'b1;
      rd_q    <= 1'b1;
      hit_q   <= 1'b0;
      lvl_q   <= '0;
      poll_q  <= 1'b0;
      prd_q   <= 1'b0;
      pbyte_q <= '0;
    end else begin
      phase_q <= phase_d;
      irq_q   <= irq_i;
      pend_q  <= pend_d;
      isr_q   <= isr_d;
      inta_q  <= inta_n_i;
      rd_q    <= rd_n_i;
      if (ack_cap) begin
        hit_q <= win_vld_i;
        lvl_q <= win_vld_i ? win_lvl_i : LVL_DFLT;
      end
      if (poll_arm_i)    poll_q <= 1'b1;
      else if (poll_cap) poll_q <= 1'b0;
      if (poll_cap) begin
        prd_q   <= 1'b1;
        pbyte_q <= win_vld_i ? {1'b1, {(7-LW){1'b0}}, win_lvl_i} : 8'h00;
      end else if (r_rise) begin
        prd_q   <= 1'b0;
      end
    end
  end

  assign slave_hit = slave_map_i[lvl_q];
  assign vec_ok    = ~casc_i | (master_i ? ~slave_hit : (cas_i == my_id_i));
  assign vec_on    = (phase_q == PH_TWO) & vec_ok;
  assign cas_win   = (phase_q == PH_GAP) | (phase_q == PH_TWO);

  assign pend_o  = pend_q;
  assign insvc_o = isr_q;
  assign cas_o   = (casc_i & master_i & cas_win & slave_hit) ? lvl_q : '0;
  assign dout_o  = vec_on ? {vec_base_i, lvl_q} : (prd_q ? pbyte_q : 8'h00);
  assign doe_o   = vec_on | prd_q;
  assign int_o   = win_vld_i & (phase_q == PH_IDLE) & ~prd_q;
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
  parameter int N_IRQ = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     inta_n_i,
  input logic                     rd_n_i,
  input logic                     casc_i,
  input logic                     master_i,
  input logic                     win_vld_i,
  input logic [N_IRQ-1:0]         pend_o,
  input logic [N_IRQ-1:0]         insvc_o,
  input logic                     int_o,
  input logic [$clog2(N_IRQ)-1:0] cas_o,
  input logic                     doe_o
);
  assert_drive_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    doe_o |-> (!$past(inta_n_i) || !$past(rd_n_i)));

  assert_cas_master_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_o != '0) |-> (casc_i && master_i));

  assert_one_new_isr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(insvc_o & ~$past(insvc_o)) <= 1);

  assert_ack_clears_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((insvc_o & ~$past(insvc_o)) & pend_o) == '0);

  assert_int_needs_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> win_vld_i);
endmodule

bind intack_seq intack_seq_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta_n_i(inta_n_i), .rd_n_i(rd_n_i),
  .casc_i(casc_i), .master_i(master_i), .win_vld_i(win_vld_i),
  .pend_o(pend_o), .insvc_o(insvc_o), .int_o(int_o), .cas_o(cas_o), .doe_o(doe_o)
);

// File: tb/intack_seq_tb_top.sv
`timescale 1ns/100ps
module intack_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq = '0, smap = '0;
  logic lvl_mode = 0, aeoi = 0, casc = 0, master = 1;
  logic [2:0] my_id = '0, cas_in = '0, eoi_lvl = '0;
  logic [4:0] base = 5'h15;
  logic inta_n = 1, rd_n = 1, poll_arm = 0, eoi_stb = 0;
  logic win_vld; logic [2:0] win_lvl;
  logic [7:0] pend_o, insvc_o, dout_o; logic int_o, doe_o; logic [2:0] cas_o;
  int checks = 0, errors = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [3:0] resolve(input logic [7:0] p, input logic [7:0] s);
    for (int i = 0; i < 8; i++) begin
      if (s[i]) return 4'b0;
      if (p[i]) return {1'b1, 3'(i)};
    end
    return 4'b0;
  endfunction

  assign {win_vld, win_lvl} = resolve(pend_o, insvc_o);

  intack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .lvl_mode_i(lvl_mode), .aeoi_i(aeoi),
    .casc_i(casc), .master_i(master), .slave_map_i(smap), .my_id_i(my_id),
    .cas_i(cas_in), .vec_base_i(base), .win_vld_i(win_vld), .win_lvl_i(win_lvl),
    .inta_n_i(inta_n), .rd_n_i(rd_n), .poll_arm_i(poll_arm), .eoi_stb_i(eoi_stb),
    .eoi_lvl_i(eoi_lvl), .pend_o(pend_o), .insvc_o(insvc_o), .int_o(int_o),
    .cas_o(cas_o), .dout_o(dout_o), .doe_o(doe_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model
  logic [7:0] m_pend, m_isr, m_irqp, m_pb;
  logic m_ia, m_rd, m_hit, m_poll, m_prd;
  logic [2:0] m_lvl;
  int m_ph;

  always @(posedge clk or negedge rst_n) begin
    logic [3:0] w; logic af, ar, rf, rr; logic [7:0] setb, clrb; int ph0;
    if (!rst_n) begin
      m_pend = 0; m_isr = 0; m_irqp = 0; m_pb = 0; m_ia = 1; m_rd = 1;
      m_hit = 0; m_poll = 0; m_prd = 0; m_lvl = 0; m_ph = 0;
    end else begin
      w = resolve(m_pend, m_isr);
      af = m_ia && !inta_n; ar = !m_ia && inta_n;
      rf = m_rd && !rd_n;   rr = !m_rd && rd_n;
      ph0 = m_ph; setb = 0; clrb = 0;
      if (ph0 == 0 && af) begin
        m_ph = 1; m_hit = w[3]; m_lvl = w[3] ? w[2:0] : 3'd7;
        if (w[3]) setb[w[2:0]] = 1'b1;
      end else if (ph0 == 1 && ar) m_ph = 2;
      else if (ph0 == 2 && af) m_ph = 3;
      else if (ph0 == 3 && ar) begin
        m_ph = 0;
        if (aeoi && m_hit) clrb[m_lvl] = 1'b1;
      end
      if (ph0 == 0 && !af && m_poll && rf) begin
        m_prd = 1; m_poll = 0;
        m_pb = w[3] ? {1'b1, 4'b0, w[2:0]} : 8'h00;
        if (w[3]) setb[w[2:0]] = 1'b1;
      end else if (rr) m_prd = 0;
      if (poll_arm) m_poll = 1;
      if (eoi_stb) clrb[eoi_lvl] = 1'b1;
      m_pend = ((m_pend & irq) | (lvl_mode ? irq : (irq & ~m_irqp))) & ~setb;
      m_isr  = (m_isr | setb) & ~clrb;
      m_irqp = irq; m_ia = inta_n; m_rd = rd_n;
    end
  end

  always @(negedge clk) begin
    logic ok, von; logic [7:0] ed;
    if (rst_n && !done) begin
      ok  = !casc || (master ? !smap[m_lvl] : (cas_in == my_id));
      von = (m_ph == 3) && ok;
      ed  = von ? {base, m_lvl} : (m_prd ? m_pb : 8'h00);
      chk(lvl_mode ? "R2" : "R1", "pend", pend_o, m_pend);
      chk("R3", "insvc", insvc_o, m_isr);
      chk("R4", "doe", doe_o, von || m_prd);
      chk("R4", "dout", dout_o, ed);
      chk("R7", "cas", cas_o,
          (casc && master && (m_ph == 2 || m_ph == 3) && smap[m_lvl]) ? m_lvl : 3'd0);
      chk("R10", "int", int_o, resolve(m_pend, m_isr)[3] && m_ph == 0 && !m_prd);
    end
  end

  task automatic ack(input logic [7:0] gap_or, output logic [7:0] vec, output logic drv,
                     output logic [2:0] casg, output logic drv1, output logic intg);
    @(negedge clk) inta_n = 0;
    @(negedge clk); drv1 = doe_o;
    @(negedge clk) inta_n = 1; irq = irq | gap_or;
    @(negedge clk);
    @(negedge clk); casg = cas_o; intg = int_o; inta_n = 0;
    @(negedge clk);
    @(negedge clk); vec = dout_o; drv = doe_o; inta_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic poll(input logic arm, output logic [7:0] b, output logic d, output logic ig);
    if (arm) begin
      @(negedge clk) poll_arm = 1;
      @(negedge clk) poll_arm = 0;
    end else @(negedge clk);
    rd_n = 0;
    @(negedge clk);
    @(negedge clk); b = dout_o; d = doe_o; ig = int_o; rd_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic eoi(input logic [2:0] l);
    @(negedge clk) begin eoi_stb = 1; eoi_lvl = l; end
    @(negedge clk) eoi_stb = 0;
    @(negedge clk);
  endtask

  task automatic eoi_all();
    for (int i = 0; i < 8; i++) eoi(3'(i));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1; summary(); $finish;
    end
  end

  initial begin
    logic [7:0] v; logic d, d1, ig; logic [2:0] cg;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "reset int", int_o, 0);
    chk("R3", "reset insvc", insvc_o, 0);
    chk("R4", "reset doe", doe_o, 0);
    chk("R7", "reset cas", cas_o, 0);

    // single edge request, no auto clear
    irq = 8'h08; repeat (2) @(negedge clk);
    chk("R1", "edge set", pend_o, 8'h08);
    chk("R10", "int raised", int_o, 1);
    ack(0, v, d, cg, d1, ig);
    chk("R3", "bus idle first strobe", d1, 0);
    chk("R4", "vector lvl3", v, {base, 3'd3});
    chk("R4", "vector drive", d, 1);
    chk("R3", "isr set", insvc_o, 8'h08);
    chk("R6", "isr held", insvc_o, 8'h08);
    chk("R1", "held line not re-requested", pend_o, 8'h00);
    eoi(3);
    chk("R6", "eoi clears", insvc_o, 8'h00);
    irq = 0; repeat (2) @(negedge clk);

    // two requests together, nesting, then auto clear
    irq = 8'h24; repeat (2) @(negedge clk);
    chk("R1", "two edges", pend_o, 8'h24);
    ack(0, v, d, cg, d1, ig);
    chk("R4", "winner lvl2", v, {base, 3'd2});
    chk("R3", "pend after", pend_o, 8'h20);
    chk("R10", "nested block", int_o, 0);
    eoi(2);
    chk("R10", "unblocked", int_o, 1);
    aeoi = 1;
    ack(0, v, d, cg, d1, ig);
    chk("R4", "winner lvl5", v, {base, 3'd5});
    chk("R6", "auto clear", insvc_o, 8'h00);
    chk("R1", "held 5 no rerequest", pend_o, 8'h00);
    aeoi = 0; irq = 0; repeat (2) @(negedge clk);

    // request withdrawn before acknowledge
    irq = 8'h02; repeat (2) @(negedge clk);
    irq = 0; repeat (2) @(negedge clk);
    chk("R1", "dropped", pend_o, 8'h00);
    ack(0, v, d, cg, d1, ig);
    chk("R5", "default vector", v, {base, 3'd7});
    chk("R5", "no isr", insvc_o, 8'h00);

    // level mode
    lvl_mode = 1; irq = 8'h10; repeat (2) @(negedge clk);
    chk("R2", "level set", pend_o, 8'h10);
    ack(0, v, d, cg, d1, ig);
    chk("R4", "vector lvl4", v, {base, 3'd4});
    chk("R2", "level re-request", pend_o, 8'h10);
    chk("R3", "isr4", insvc_o, 8'h10);
    irq = 0; repeat (2) @(negedge clk);
    chk("R2", "level drop", pend_o, 8'h00);
    eoi(4); lvl_mode = 0;

    // cascade master
    casc = 1; master = 1; smap = 8'h04;
    irq = 8'h04; repeat (2) @(negedge clk);
    ack(0, v, d, cg, d1, ig);
    chk("R7", "slave id out", cg, 3'd2);
    chk("R7", "master silent", d, 0);
    chk("R7", "cas low after", cas_o, 0);
    eoi(2); irq = 0; repeat (2) @(negedge clk);
    irq = 8'h40; repeat (2) @(negedge clk);
    ack(0, v, d, cg, d1, ig);
    chk("R7", "no slave id", cg, 3'd0);
    chk("R7", "master drives", d, 1);
    chk("R7", "master vector", v, {base, 3'd6});
    eoi(6); irq = 0; repeat (2) @(negedge clk);

    // cascade slave
    master = 0; my_id = 3'd5; cas_in = 3'd5;
    irq = 8'h01; repeat (2) @(negedge clk);
    ack(0, v, d, cg, d1, ig);
    chk("R8", "id match drives", d, 1);
    chk("R8", "slave vector", v, {base, 3'd0});
    eoi(0); irq = 0; repeat (2) @(negedge clk);
    cas_in = 3'd3; irq = 8'h01; repeat (2) @(negedge clk);
    ack(0, v, d, cg, d1, ig);
    chk("R8", "id mismatch silent", d, 0);
    chk("R8", "mismatch bus", v, 8'h00);
    eoi(0); irq = 0; casc = 0; master = 1; cas_in = 0; smap = 0;
    repeat (2) @(negedge clk);

    // poll
    irq = 8'h48; repeat (2) @(negedge clk);
    poll(0, v, d, ig);
    chk("R9", "plain read silent", d, 0);
    chk("R9", "plain read no change", pend_o, 8'h48);
    poll(1, v, d, ig);
    chk("R9", "poll byte", v, 8'h83);
    chk("R9", "poll drive", d, 1);
    chk("R10", "int low in poll", ig, 0);
    chk("R9", "poll isr", insvc_o, 8'h08);
    chk("R9", "poll pend", pend_o, 8'h40);
    eoi(3);
    poll(1, v, d, ig);
    chk("R9", "poll byte 6", v, 8'h86);
    eoi(6); irq = 0; repeat (2) @(negedge clk);
    poll(1, v, d, ig);
    chk("R9", "empty poll", v, 8'h00);
    chk("R9", "empty poll isr", insvc_o, 8'h00);

    // higher request during sequence
    irq = 8'h20; repeat (2) @(negedge clk);
    ack(8'h02, v, d, cg, d1, ig);
    chk("R10", "int held during sequence", ig, 0);
    chk("R10", "int after sequence", int_o, 1);
    ack(0, v, d, cg, d1, ig);
    chk("R4", "preempt vector", v, {base, 3'd1});
    eoi_all(); irq = 0; repeat (3) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule